// File: doc/BRIEF.md
# Unaligned Sector DMA Aligner

This block joins a byte-oriented DMA data stream to a storage port that only understands whole sectors. A request carries a byte offset, a byte length and a direction. The block widens the byte window to the enclosing run of sectors and issues one sector command per sector, in ascending order. On a read it passes on only the bytes inside the requested window. On a write it streams the new bytes into place. Where a write covers only part of a sector, it first reads that sector into a local buffer so that the bytes outside the window are written back unchanged.

A second addressing mode serves optical-style transfers. There the window starts at a logical block number times the large block size (2048 bytes by default), and the sector machinery is the same. A remaining-byte counter runs down as bytes move. When it runs out, the block raises a one-cycle interrupt and sets its ready status. The `run` input pauses all data and command traffic without losing position. An error reported by the storage port aborts the transfer.

Top module: `sector_dma_aligner`

## Requirements
- R1: After reset `busy`=0, `irq`=0, `err`=0 and `dev_ready`=1, and no command is offered.
- R2: A read delivers on `dma_out_data` exactly the bytes at storage addresses start .. start+len-1, in ascending address order, one per `dma_out_valid` cycle. Surplus bytes of the first and last sectors are dropped.
- R3: A read of a nonzero length issues exactly one read command (`cmd_write`=0) for each sector from start>>SECT_LG through (start+len-1)>>SECT_LG.
- R4: A write places DMA input byte k (k counted from 0 on `dma_in_valid`&`dma_in_ready`) at storage address start+k for every k below len.
- R5: On a write, a first or last sector that the window covers only in part is read first (`cmd_write`=0) and then written (`cmd_write`=1). Its bytes outside the window keep their old values. Fully covered sectors get a single write command.
- R6: With `req_optical`=1 the window start is `req_lbn` << BLK_LG, and `req_offset` is ignored.
- R7: Completion raises `irq` for exactly one cycle, sets `dev_ready`=1 and clears `busy`. `dev_ready` is 0 while busy, and the remaining-byte count is zero at successful completion.
- R8: A zero-length request raises `irq` in the cycle after acceptance and issues no storage command.
- R9: While `run`=0, no command is offered and no byte handshake takes place on either side. Raising `run` again resumes the transfer with correct data.
- R10: `st_err` high while busy aborts the transfer, sets `err`=1 and raises `irq`. `err` clears when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Channel active; 0 pauses all traffic |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write to storage, 0 = read |
| req_optical | input | 1 | 1 = start from block number |
| req_offset | input | OFF_W | Byte offset (byte mode) |
| req_lbn | input | LBN_W | Logical block number (optical mode) |
| req_len | input | LEN_W | Byte length |
| busy | output | 1 | Transfer in progress |
| dev_ready | output | 1 | Ready status |
| irq | output | 1 | One-cycle completion/abort pulse |
| err | output | 1 | Last transfer aborted by storage error |
| dma_out_valid | output | 1 | Read byte valid toward DMA |
| dma_out_data | output | 8 | Read byte |
| dma_in_valid | input | 1 | Write byte available from DMA |
| dma_in_data | input | 8 | Write byte |
| dma_in_ready | output | 1 | Write byte taken |
| cmd_valid | output | 1 | Sector command offered |
| cmd_write | output | 1 | 1 = sector write, 0 = sector read |
| cmd_sector | output | OFF_W+1-SECT_LG | Sector number |
| cmd_ready | input | 1 | Command accepted |
| st_rvalid | input | 1 | Storage read byte valid |
| st_rdata | input | 8 | Storage read byte |
| st_rready | output | 1 | Storage read byte taken |
| st_wvalid | output | 1 | Storage write byte valid |
| st_wdata | output | 8 | Storage write byte |
| st_wready | input | 1 | Storage write byte taken |
| st_err | input | 1 | Storage error report |

## Verification
A wrong window boundary or a bad in-range test shows up at once in the count and content of the delivered read bytes. On writes it appears as a corrupted neighbour byte in the storage image, seen as soon as the transfer ends. A stale sector counter or a wrong partial-sector decision changes the number of storage commands, which is compared after every request. A remaining-count or completion fault moves or repeats the interrupt, and that is seen within a few cycles of the last byte.

// File: rtl/sal_pkg.sv
package sal_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_CMD  = 3'd1,
    S_FILL = 3'd2,
    S_RDX  = 3'd3,
    S_WRX  = 3'd4
  } sal_state_e;
endpackage

// File: rtl/sal_geom.sv
module sal_geom #(
  parameter int OFF_W   = 24,
  parameter int LEN_W   = 16,
  parameter int LBN_W   = 12,
  parameter int SECT_LG = 9,
  parameter int BLK_LG  = 11,
  localparam int SW     = OFF_W + 1 - SECT_LG
) (
  input  logic               optical,
  input  logic [OFF_W-1:0]   offset,
  input  logic [LBN_W-1:0]   lbn,
  input  logic [LEN_W-1:0]   len,
  output logic [OFF_W-1:0]   start,
  output logic [OFF_W:0]     stop,
  output logic [SW-1:0]      first_sec,
  output logic [SW-1:0]      last_sec,
  output logic               first_partial
);
  logic [OFF_W:0] stop_m1;

  always_comb begin
    start         = optical ? (OFF_W'(lbn) << BLK_LG) : offset;
    stop          = {1'b0, start} + (OFF_W+1)'(len);
    stop_m1       = stop - (OFF_W+1)'(1);
    first_sec     = SW'({1'b0, start} >> SECT_LG);
    last_sec      = SW'(stop_m1 >> SECT_LG);
    first_partial = (start[SECT_LG-1:0] != '0) ||
                    ((first_sec == last_sec) && (stop[SECT_LG-1:0] != '0));
  end
endmodule

// File: rtl/sal_secbuf.sv
module sal_secbuf #(
  parameter int SECT_LG = 9,
  localparam int DEPTH  = 1 << SECT_LG
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [SECT_LG-1:0] wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [SECT_LG-1:0] rd_addr,
  output logic [7:0]         rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sector_dma_aligner.sv
module sector_dma_aligner #(
  parameter int OFF_W   = 24,
  parameter int LEN_W   = 16,
  parameter int LBN_W   = 12,
  parameter int SECT_LG = 9,
  parameter int BLK_LG  = 11,
  localparam int SW     = OFF_W + 1 - SECT_LG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_optical,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [LBN_W-1:0] req_lbn,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             dev_ready,
  output logic             irq,
  output logic             err,
  output logic             dma_out_valid,
  output logic [7:0]       dma_out_data,
  input  logic             dma_in_valid,
  input  logic [7:0]       dma_in_data,
  output logic             dma_in_ready,
  output logic             cmd_valid,
  output logic             cmd_write,
  output logic [SW-1:0]    cmd_sector,
  input  logic             cmd_ready,
  input  logic             st_rvalid,
  input  logic [7:0]       st_rdata,
  output logic             st_rready,
  output logic             st_wvalid,
  output logic [7:0]       st_wdata,
  input  logic             st_wready,
  input  logic             st_err
);
  import sal_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  sal_state_e         state_q, state_d;
  logic [SW-1:0]      cur_q, cur_d, last_q, last_d;
  logic [SECT_LG-1:0] idx_q, idx_d;
  logic [OFF_W-1:0]   start_q, start_d;
  logic [OFF_W:0]     stop_q, stop_d;
  logic [LEN_W-1:0]   remain_q, remain_d, bidx_q, bidx_d;
  logic               wrph_q, wrph_d, iswr_q, iswr_d;
  logic               irq_q, irq_d, err_q, err_d, rdy_q, rdy_d;

  logic [OFF_W-1:0] g_start;
  logic [OFF_W:0]   g_stop;
  logic [SW-1:0]    g_first, g_last;
  logic             g_part;

  sal_geom #(.OFF_W(OFF_W), .LEN_W(LEN_W), .LBN_W(LBN_W),
             .SECT_LG(SECT_LG), .BLK_LG(BLK_LG)) u_geom (
    .optical(req_optical), .offset(req_offset), .lbn(req_lbn), .len(req_len),
    .start(g_start), .stop(g_stop), .first_sec(g_first), .last_sec(g_last),
    .first_partial(g_part)
  );

  // datapath decode for the current byte slot
  logic [OFF_W:0] pos;
  logic           in_rng, idx_last, rbeat, wbeat, beat, moved, buf_we;
  logic [SW-1:0]  cur_nx;
  logic [7:0]     buf_rd;

  assign pos      = {cur_q, idx_q};
  assign in_rng   = (pos >= {1'b0, start_q}) && (pos < stop_q);
  assign idx_last = (idx_q == '1);
  assign cur_nx   = cur_q + SW'(1);

  assign cmd_valid  = run && (state_q == S_CMD);
  assign cmd_write  = wrph_q;
  assign cmd_sector = cur_q;

  assign st_rready     = run && ((state_q == S_FILL) || (state_q == S_RDX));
  assign rbeat         = st_rready && st_rvalid;
  assign dma_out_valid = rbeat && (state_q == S_RDX) && in_rng;
  assign dma_out_data  = st_rdata;

  assign st_wvalid    = run && (state_q == S_WRX) && (in_rng ? dma_in_valid : 1'b1);
  assign st_wdata     = in_rng ? dma_in_data : buf_rd;
  assign dma_in_ready = run && (state_q == S_WRX) && in_rng && st_wready;
  assign wbeat        = st_wvalid && st_wready;

  assign beat   = rbeat || wbeat;
  assign moved  = beat && in_rng && (state_q != S_FILL);
  assign buf_we = rbeat && (state_q == S_FILL);

  sal_secbuf #(.SECT_LG(SECT_LG)) u_buf (
    .clk(clk), .wr_en(buf_we), .wr_addr(idx_q), .wr_data(st_rdata),
    .rd_addr(idx_q), .rd_data(buf_rd)
  );

  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    last_d   = last_q;
    idx_d    = idx_q;
    start_d  = start_q;
    stop_d   = stop_q;
    remain_d = remain_q;
    bidx_d   = bidx_q;
    wrph_d   = wrph_q;
    iswr_d   = iswr_q;
    irq_d    = 1'b0;
    err_d    = err_q;
    rdy_d    = rdy_q;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          err_d    = 1'b0;
          remain_d = req_len;
          bidx_d   = '0;
          iswr_d   = req_write;
          start_d  = g_start;
          stop_d   = g_stop;
          cur_d    = g_first;
          last_d   = g_last;
          if (req_len == '0) begin
            irq_d = 1'b1;
            rdy_d = 1'b1;
          end else begin
            rdy_d   = 1'b0;
            state_d = S_CMD;
            wrph_d  = req_write && !g_part;
          end
        end
      end
      S_CMD: begin
        if (cmd_valid && cmd_ready) begin
          idx_d   = '0;
          state_d = !iswr_q ? S_RDX : (wrph_q ? S_WRX : S_FILL);
        end
      end
      S_FILL: begin
        if (rbeat) begin
          idx_d = idx_q + SECT_LG'(1);
          if (idx_last) begin
            state_d = S_CMD;
            wrph_d  = 1'b1;
          end
        end
      end
      default: begin
        if (beat) begin
          idx_d = idx_q + SECT_LG'(1);
          if (moved) begin
            remain_d = remain_q - LEN_W'(1);
            bidx_d   = bidx_q + LEN_W'(1);
          end
          if (idx_last) begin
            if (cur_q == last_q) begin
              state_d = S_IDLE;
              irq_d   = 1'b1;
              rdy_d   = 1'b1;
            end else begin
              cur_d   = cur_nx;
              state_d = S_CMD;
              wrph_d  = iswr_q &&
                        !((cur_nx == last_q) && (stop_q[SECT_LG-1:0] != '0));
            end
          end
        end
      end
    endcase
    if ((state_q != S_IDLE) && st_err) begin
      state_d = S_IDLE;
      err_d   = 1'b1;
      irq_d   = 1'b1;
      rdy_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q  <= S_IDLE;
      cur_q    <= '0;
      last_q   <= '0;
      idx_q    <= '0;
      start_q  <= '0;
      stop_q   <= '0;
      remain_q <= '0;
      bidx_q   <= '0;
      wrph_q   <= 1'b0;
      iswr_q   <= 1'b0;
      irq_q    <= 1'b0;
      err_q    <= 1'b0;
      rdy_q    <= 1'b1;
    end else begin
      state_q  <= state_d;
      cur_q    <= cur_d;
      last_q   <= last_d;
      idx_q    <= idx_d;
      start_q  <= start_d;
      stop_q   <= stop_d;
      remain_q <= remain_d;
      bidx_q   <= bidx_d;
      wrph_q   <= wrph_d;
      iswr_q   <= iswr_d;
      irq_q    <= irq_d;
      err_q    <= err_d;
      rdy_q    <= rdy_d;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign dev_ready = rdy_q;
  assign irq       = irq_q;
  assign err       = err_q;
endmodule

// File: rtl/sal_checker.sv
module sal_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             cmd_valid,
  input logic             st_rready,
  input logic             st_wvalid,
  input logic             dma_in_ready,
  input logic             dma_out_valid,
  input logic             busy,
  input logic             dev_ready,
  input logic             irq,
  input logic             err,
  input logic [LEN_W-1:0] remain
);
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!cmd_valid && !st_rready && !st_wvalid && !dma_in_ready)); // R9
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R7
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !err) |-> (remain == '0)); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dev_ready); // R7
  AST_OUT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dma_out_valid |-> busy); // R2
  AST_ERR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> irq); // R10
endmodule

bind sector_dma_aligner sal_checker #(.LEN_W(LEN_W)) u_sal_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cmd_valid(cmd_valid),
  .st_rready(st_rready), .st_wvalid(st_wvalid), .dma_in_ready(dma_in_ready),
  .dma_out_valid(dma_out_valid), .busy(busy), .dev_ready(dev_ready),
  .irq(irq), .err(err), .remain(remain_q)
);

// File: tb/sector_dma_aligner_bench.sv
`timescale 1ns/1ps
module sector_dma_aligner_bench;
  localparam int OFF_W = 8, LEN_W = 6, LBN_W = 2, SECT_LG = 3, BLK_LG = 5;
  localparam int SW = OFF_W + 1 - SECT_LG;
  localparam int SB = 1 << SECT_LG;
  localparam int MEMN = 1 << (OFF_W + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, run, req_valid, req_write, req_optical;
  logic [OFF_W-1:0] req_offset;
  logic [LBN_W-1:0] req_lbn;
  logic [LEN_W-1:0] req_len;
  logic busy, dev_ready, irq, err, dma_out_valid, dma_in_ready;
  logic [7:0] dma_out_data, dma_in_data, st_rdata, st_wdata;
  logic dma_in_valid, cmd_valid, cmd_write, cmd_ready;
  logic [SW-1:0] cmd_sector;
  logic st_rvalid, st_rready, st_wvalid, st_wready, st_err;

  sector_dma_aligner #(.OFF_W(OFF_W), .LEN_W(LEN_W), .LBN_W(LBN_W),
                       .SECT_LG(SECT_LG), .BLK_LG(BLK_LG)) u_sector_dma_aligner (.*);

  int checks = 0, fails = 0, cyc = 0;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 5 + 1) & 255);
  endfunction

  // storage model
  logic [7:0] smem [MEMN];
  logic [SW-1:0] m_sec;
  logic [SECT_LG-1:0] m_idx;
  logic m_rd, m_wr;
  int cmd_cnt;
  assign cmd_ready = 1'b1;
  assign st_rvalid = m_rd;
  assign st_wready = m_wr;
  assign st_rdata  = smem[{m_sec, m_idx}];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rd <= 1'b0; m_wr <= 1'b0; cmd_cnt <= 0; m_sec <= '0; m_idx <= '0;
      for (int i = 0; i < MEMN; i++) smem[i] <= pat(i);
    end else begin
      if (cmd_valid && cmd_ready) begin
        m_sec <= cmd_sector; m_idx <= '0;
        m_rd <= !cmd_write; m_wr <= cmd_write; cmd_cnt <= cmd_cnt + 1;
      end
      if (st_rvalid && st_rready) begin
        m_idx <= m_idx + 1'b1;
        if (m_idx == '1) m_rd <= 1'b0;
      end
      if (st_wvalid && st_wready) begin
        smem[{m_sec, m_idx}] <= st_wdata;
        m_idx <= m_idx + 1'b1;
        if (m_idx == '1) m_wr <= 1'b0;
      end
    end
  end

  // DMA sink and source
  logic [7:0] cap [4096];
  int cap_n, src_k;
  int src_k0, src_seed;
  assign dma_in_valid = 1'b1;
  assign dma_in_data  = 8'((src_seed + (src_k - src_k0) * 13) & 255);
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_n <= 0; src_k <= 0;
    end else begin
      if (dma_out_valid) begin
        cap[cap_n % 4096] <= dma_out_data;
        cap_n <= cap_n + 1;
      end
      if (dma_in_valid && dma_in_ready) src_k <= src_k + 1;
    end
  end

  logic [7:0] exp_mem [MEMN];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic issue(input bit wr, input bit opt, input int off, input int lbn, input int len);
    @(negedge clk);
    req_write = wr; req_optical = opt; req_offset = OFF_W'(off);
    req_lbn = LBN_W'(lbn); req_len = LEN_W'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 800; t++) begin
      if (irq) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  function automatic int exp_cmds(input bit wr, input int st, input int len);
    int f, l, n, hd, tl;
    if (len == 0) return 0;
    f = st / SB; l = (st + len - 1) / SB; n = l - f + 1;
    if (!wr) return n;
    hd = (st % SB) != 0;
    tl = ((st + len) % SB) != 0 && (f != l || !hd);
    return n + hd + tl;
  endfunction

  task automatic do_read(input bit opt, input int off, input int lbn, input int len, input string req);
    int base, c0, st, bad;
    bit seen;
    st = opt ? lbn * (1 << BLK_LG) : off;
    base = cap_n; c0 = cmd_cnt;
    issue(1'b0, opt, off, lbn, len);
    wait_irq(seen);
    chk(seen && dev_ready && !busy, "R7 completion", int'(seen), 1);
    chk(cap_n - base == len, {req, " byte count"}, cap_n - base, len);
    bad = 0;
    for (int i = 0; i < len && i < cap_n - base; i++)
      if (cap[(base + i) % 4096] !== exp_mem[st + i]) bad++;
    chk(bad == 0, {req, " data"}, bad, 0);
    chk(cmd_cnt - c0 == exp_cmds(1'b0, st, len), "R3 command count", cmd_cnt - c0, exp_cmds(1'b0, st, len));
  endtask

  task automatic do_write(input bit opt, input int off, input int lbn, input int len, input int seed);
    int c0, st, bad;
    bit seen;
    st = opt ? lbn * (1 << BLK_LG) : off;
    c0 = cmd_cnt; src_k0 = src_k; src_seed = seed;
    for (int i = 0; i < len; i++) exp_mem[st + i] = 8'((seed + i * 13) & 255);
    issue(1'b1, opt, off, lbn, len);
    wait_irq(seen);
    chk(seen && dev_ready && !busy, "R7 write completion", int'(seen), 1);
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < MEMN; i++) if (smem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, opt ? "R6 optical write image" : "R4/R5 write image", bad, 0);
    chk(cmd_cnt - c0 == exp_cmds(1'b1, st, len), "R5 command count", cmd_cnt - c0, exp_cmds(1'b1, st, len));
  endtask

  initial begin
    int c0, n0;
    bit seen;
    rst_n = 1'b0; run = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_optical = 1'b0;
    req_offset = '0; req_lbn = '0; req_len = '0; st_err = 1'b0;
    src_k0 = 0; src_seed = 0;
    for (int i = 0; i < MEMN; i++) exp_mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !irq && !err && dev_ready && !cmd_valid, "R1 reset state", int'(busy), 0);

    // zero-length request
    c0 = cmd_cnt;
    issue(1'b0, 1'b0, 5, 0, 0);
    chk(irq == 1'b1, "R8 zero-length irq", int'(irq), 1);
    @(negedge clk);
    chk(cmd_cnt == c0 && !busy, "R8 zero-length commands", cmd_cnt - c0, 0);

    // read sweep: every head/tail alignment and span
    for (int off = 0; off < 20; off++)
      for (int len = 0; len < 18; len++)
        do_read(1'b0, off, 0, len, "R2 read");

    // write sweep
    for (int off = 0; off < 20; off++)
      for (int len = 1; len < 18; len++)
        do_write(1'b0, off + 40, 0, len, off * 17 + len);
    for (int off = 36; off < 80; off += 3) do_read(1'b0, off, 0, 11, "R4 readback");

    // optical mode: req_offset must be ignored
    for (int lbn = 0; lbn < 4; lbn++)
      for (int len = 1; len < 13; len++)
        do_read(1'b1, 200, lbn, len, "R6 optical read");
    do_write(1'b1, 7, 2, 21, 99);
    do_read(1'b1, 0, 2, 30, "R6 optical readback");

    // pause during a read
    n0 = cap_n; c0 = cmd_cnt;
    issue(1'b0, 1'b0, 3, 0, 20);
    repeat (5) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    c0 = cmd_cnt; n0 = cap_n;
    repeat (20) @(negedge clk);
    chk(cmd_cnt == c0 && cap_n == n0 && busy, "R9 paused traffic", cap_n - n0, 0);
    run = 1'b1;
    n0 = cap_n - 0;
    wait_irq(seen);
    chk(seen, "R9 resume completes", int'(seen), 1);
    do_read(1'b0, 3, 0, 20, "R9 data after pause");

    // storage error abort
    issue(1'b1, 1'b0, 5, 0, 20);
    repeat (4) @(negedge clk);
    st_err = 1'b1;
    @(negedge clk);
    st_err = 1'b0;
    chk(irq && err && !busy, "R10 error abort", int'(err), 1);
    @(negedge clk);
    chk(err == 1'b1, "R10 error held", int'(err), 1);
    issue(1'b0, 1'b0, 0, 0, 0);
    chk(err == 1'b0, "R10 error cleared on accept", int'(err), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule